// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Full Flag

This block is an 18-bit dual-clock FIFO whose depth is a parameter (512 by default, 1024 also supported). Words are written on the write clock and read on the read clock. Each side has active-low enables. Read and write pointers cross between the two domains as Gray codes through two-flop synchronizers. The block drives a full flag on the write side, an empty flag on the read side and a programmable almost-full flag.

A load input takes the data bus and the enables away from the memory. While load is low, a write stores the input word into a small register file: an almost-empty offset, an almost-full offset and, in enhanced mode, a control word. A read returns the contents of that register file. The write side and the read side each keep their own index into the register file. The index moves through the states IDX_AE, IDX_AF and IDX_CTRL. Only a load access makes it step. It goes IDX_AE to IDX_AF, then IDX_AF to IDX_CTRL in enhanced mode or IDX_AF back to IDX_AE in compatible mode, and IDX_CTRL back to IDX_AE. A retransmit input rewinds the read pointer to memory location zero, so data already read can be replayed.

The operating mode is sampled from a mode input while reset is held, and it is kept after reset ends. Enhanced mode adds a second write enable and a second read enable. The control word in that mode can do two things: register the almost-full flag on the write clock, and make reads depend on an output-enable input.

Top module: `dcfifo_pflag`

## Requirements
- R1: While rst_n is low and just after it rises, empty_n is 0, full_n is 1, paf_n is 1 and dout is 0. Both offsets hold DEPTH/8-1 (63 for 512 words), the control bits are 0, and both load indices are at IDX_AE.
- R2: A write-clock edge with load_n low and the effective write enable active stores din into the register at the write index and steps that index. It does not write the memory and does not move the write pointer.
- R3: A read-clock edge with load_n low and the effective read enable active puts the register at the read index onto dout and steps the read index. The read pointer does not move. Offsets read back zero-extended. The control word reads back with only bit 4 and bit 5 possibly set.
- R4: With load_n high, words come out of dout in the order they were written. dout changes only on a read-clock edge that performs a read.
- R5: full_n is 0 while DEPTH words are held. A write attempted while full_n is 0 changes neither the memory nor the write pointer.
- R6: empty_n is 0 while no word is held. A read attempted while empty_n is 0 leaves dout and the read pointer unchanged.
- R7: paf_n is 0 while the fill level seen by the write side is at least DEPTH minus the almost-full offset. When it is decoded directly, the flag changes right after the write edge that reaches the threshold.
- R8: retx high at a read-clock edge sets the read pointer to location 0. The words written since reset are then read again from the first one.
- R9: The mode is the value of mode_enh while rst_n is low. In compatible mode (mode_enh 0), wr_en2_n, rd_en2_n and oe_n have no effect, the load index never reaches IDX_CTRL, and paf_n is always decoded directly.
- R10: In enhanced mode, a write (FIFO or load) takes place only when wr_en_n and wr_en2_n are both 0.
- R11: In enhanced mode, a read (FIFO or load) takes place only when rd_en_n and rd_en2_n are both 0, and also oe_n is 0 when control bit 5 is 1.
- R12: In enhanced mode with control bit 4 set to 1, paf_n is registered on the write clock and changes one write-clock edge after the edge that reaches the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mode_enh | input | 1 | Mode select sampled during reset (1 = enhanced) |
| load_n | input | 1 | Low: accesses go to the offset/control register file |
| wr_en_n | input | 1 | Active-low write enable |
| wr_en2_n | input | 1 | Active-low second write enable (enhanced mode) |
| rd_en_n | input | 1 | Active-low read enable |
| rd_en2_n | input | 1 | Active-low second read enable (enhanced mode) |
| oe_n | input | 1 | Active-low output enable, gates reads when control bit 5 is set |
| retx | input | 1 | Retransmit: rewinds the read pointer to location 0 |
| din | input | DW | Write data or register value |
| dout | output | DW | Read data or register readback |
| full_n | output | 1 | Low when full, write-clock domain |
| paf_n | output | 1 | Low when almost full |
| empty_n | output | 1 | Low when empty, read-clock domain |

## Verification
Random bursts of writes and reads with random data are run with the secondary enables held inactive in compatible mode. These check ordering and the full and empty flags, and show that the enhanced-only inputs are ignored. Load reads and writes are interleaved so that the write index and the read index are out of step, which tells separate indices from a shared one. A fill to exactly one below and exactly at the almost-full threshold is done in both flag timings, and a single write is sampled between edges, which tells the direct flag from the registered one. Full and empty overruns, a retransmit after a partial drain, and each enhanced enable held inactive alone show whether each gate acts on its own.

// File: rtl/dcfifo_pkg.sv
package dcfifo_pkg;

    // Index into the load-mode register file
    typedef enum logic [1:0] {
        IDX_AE   = 2'd0,
        IDX_AF   = 2'd1,
        IDX_CTRL = 2'd2
    } lsel_e;

    // Next index after one load access
    function automatic lsel_e lsel_step(input lsel_e cur, input logic enh);
        lsel_e nxt;
        unique case (cur)
            IDX_AE:   nxt = IDX_AF;
            IDX_AF:   nxt = enh ? IDX_CTRL : IDX_AE;
            IDX_CTRL: nxt = IDX_AE;
            default:  nxt = IDX_AE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/dcfifo_sync2.sv
module dcfifo_sync2 #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/dcfifo_ram.sv
module dcfifo_ram #(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [0:WORDS-1];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcfifo_wr_side.sv
module dcfifo_wr_side
    import dcfifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          enh,
    input  logic          load_n,
    input  logic          wen_n,
    input  logic          wen2_n,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_sync,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic [AW:0]   wgray,
    output logic [AW:0]   wbin,
    output logic          full_n,
    output logic          paf_n,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off,
    output logic          ctl_paf_reg,
    output logic          ctl_oe_gate
);
    localparam int            DEPTH   = 1 << AW;
    localparam logic [AW:0]   DEPTH_V = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] OFF_DEF = AW'(DEPTH / 8 - 1);

    lsel_e         wsel_q, wsel_d;
    logic          wr_go, lreg_wr, fifo_wr;
    logic [AW:0]   wbin_q, wbin_d, wgray_q, wgray_d;
    logic [AW:0]   rbin_s, level, thr;
    logic          full_q, paf_q, af_hit;
    logic [AW-1:0] ae_off_q, af_off_q;
    logic          paf_reg_q, oe_gate_q;

    // Effective enables and next-state decode
    always_comb begin
        wr_go   = !wen_n && (!enh || !wen2_n);
        lreg_wr = wr_go && !load_n;
        fifo_wr = wr_go && load_n && !full_q;
        wsel_d  = lreg_wr ? lsel_step(wsel_q, enh) : wsel_q;
        wbin_d  = wbin_q + {{AW{1'b0}}, fifo_wr};
        wgray_d = wbin_d ^ (wbin_d >> 1);
    end

    // Synchronized read pointer back to binary, fill level, threshold
    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            rbin_s[i] = ^(rgray_sync >> i);
        end
        level  = wbin_q - rbin_s;
        thr    = DEPTH_V - {1'b0, af_off_q};
        af_hit = (level >= thr);
    end

    // Load index state register
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wsel_q <= IDX_AE;
        end else begin
            wsel_q <= wsel_d;
        end
    end

    // Register file writes
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            ae_off_q  <= OFF_DEF;
            af_off_q  <= OFF_DEF;
            paf_reg_q <= 1'b0;
            oe_gate_q <= 1'b0;
        end else if (lreg_wr) begin
            unique case (wsel_q)
                IDX_AE:   ae_off_q <= din[AW-1:0];
                IDX_AF:   af_off_q <= din[AW-1:0];
                IDX_CTRL: begin
                    paf_reg_q <= din[4];
                    oe_gate_q <= din[5];
                end
                default:  ae_off_q <= ae_off_q;
            endcase
        end
    end

    // Pointer and flags
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            full_q  <= 1'b0;
            paf_q   <= 1'b0;
        end else begin
            wbin_q  <= wbin_d;
            wgray_q <= wgray_d;
            full_q  <= (wgray_d == {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]});
            paf_q   <= af_hit;
        end
    end

    // Outputs
    always_comb begin
        mem_we      = fifo_wr;
        mem_waddr   = wbin_q[AW-1:0];
        mem_wdata   = din;
        wgray       = wgray_q;
        wbin        = wbin_q;
        full_n      = !full_q;
        paf_n       = (enh && paf_reg_q) ? !paf_q : !af_hit;
        ae_off      = ae_off_q;
        af_off      = af_off_q;
        ctl_paf_reg = paf_reg_q;
        ctl_oe_gate = oe_gate_q;
    end
endmodule

// File: rtl/dcfifo_rd_side.sv
module dcfifo_rd_side
    import dcfifo_pkg::*;
#(
    parameter int DW = 18,
    parameter int AW = 9
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          enh,
    input  logic          load_n,
    input  logic          ren_n,
    input  logic          ren2_n,
    input  logic          oe_n,
    input  logic          retx,
    input  logic [AW:0]   wgray_sync,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    input  logic          ctl_paf_reg,
    input  logic          ctl_oe_gate,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [AW:0]   rgray,
    output logic [AW:0]   rbin,
    output logic [DW-1:0] dout,
    output logic          empty_n
);
    lsel_e         rsel_q, rsel_d;
    logic          rd_go, lreg_rd, fifo_rd;
    logic [AW:0]   rbin_q, rbin_d, rgray_q, rgray_d;
    logic          empty_q;
    logic [DW-1:0] dout_q, lreg_val;

    // Effective enables and next-state decode
    always_comb begin
        rd_go   = !ren_n && (!enh || (!ren2_n && (!ctl_oe_gate || !oe_n)));
        lreg_rd = rd_go && !load_n;
        fifo_rd = rd_go && load_n && !empty_q && !retx;
        rsel_d  = lreg_rd ? lsel_step(rsel_q, enh) : rsel_q;
        rbin_d  = retx ? '0 : rbin_q + {{AW{1'b0}}, fifo_rd};
        rgray_d = rbin_d ^ (rbin_d >> 1);
    end

    // Readback multiplexer
    always_comb begin
        unique case (rsel_q)
            IDX_AE:   lreg_val = {{(DW-AW){1'b0}}, ae_off};
            IDX_AF:   lreg_val = {{(DW-AW){1'b0}}, af_off};
            IDX_CTRL: lreg_val = {{(DW-6){1'b0}}, ctl_oe_gate, ctl_paf_reg, 4'b0000};
            default:  lreg_val = '0;
        endcase
    end

    // Load index state register
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rsel_q <= IDX_AE;
        end else begin
            rsel_q <= rsel_d;
        end
    end

    // Pointer, empty flag, output word
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            empty_q <= 1'b1;
            dout_q  <= '0;
        end else begin
            rbin_q  <= rbin_d;
            rgray_q <= rgray_d;
            empty_q <= (rgray_d == wgray_sync);
            if (lreg_rd) begin
                dout_q <= lreg_val;
            end else if (fifo_rd) begin
                dout_q <= mem_rdata;
            end
        end
    end

    // Outputs
    always_comb begin
        mem_raddr = rbin_q[AW-1:0];
        rgray     = rgray_q;
        rbin      = rbin_q;
        dout      = dout_q;
        empty_n   = !empty_q;
    end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
    parameter int DW    = 18,
    parameter int DEPTH = 512
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          mode_enh,
    input  logic          load_n,
    input  logic          wr_en_n,
    input  logic          wr_en2_n,
    input  logic          rd_en_n,
    input  logic          rd_en2_n,
    input  logic          oe_n,
    input  logic          retx,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          full_n,
    output logic          paf_n,
    output logic          empty_n
);
    localparam int AW = $clog2(DEPTH);

    logic          enh_q;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, mem_raddr, ae_off, af_off;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [AW:0]   wr_gray, rd_gray, wr_gray_s, rd_gray_s, wr_bin, rd_bin;
    logic          ctl_paf_reg, ctl_oe_gate;

    // Mode follows mode_enh while reset is held and is kept afterwards
    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            enh_q <= mode_enh;
        end
    end

    dcfifo_wr_side #(.DW(DW), .AW(AW)) wr_i (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .enh         (enh_q),
        .load_n      (load_n),
        .wen_n       (wr_en_n),
        .wen2_n      (wr_en2_n),
        .din         (din),
        .rgray_sync  (rd_gray_s),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .wgray       (wr_gray),
        .wbin        (wr_bin),
        .full_n      (full_n),
        .paf_n       (paf_n),
        .ae_off      (ae_off),
        .af_off      (af_off),
        .ctl_paf_reg (ctl_paf_reg),
        .ctl_oe_gate (ctl_oe_gate)
    );

    dcfifo_rd_side #(.DW(DW), .AW(AW)) rd_i (
        .rd_clk      (rd_clk),
        .rst_n       (rst_n),
        .enh         (enh_q),
        .load_n      (load_n),
        .ren_n       (rd_en_n),
        .ren2_n      (rd_en2_n),
        .oe_n        (oe_n),
        .retx        (retx),
        .wgray_sync  (wr_gray_s),
        .ae_off      (ae_off),
        .af_off      (af_off),
        .ctl_paf_reg (ctl_paf_reg),
        .ctl_oe_gate (ctl_oe_gate),
        .mem_rdata   (mem_rdata),
        .mem_raddr   (mem_raddr),
        .rgray       (rd_gray),
        .rbin        (rd_bin),
        .dout        (dout),
        .empty_n     (empty_n)
    );

    dcfifo_sync2 #(.W(AW+1)) r2w_i (
        .clk   (wr_clk),
        .rst_n (rst_n),
        .d     (rd_gray),
        .q     (rd_gray_s)
    );

    dcfifo_sync2 #(.W(AW+1)) w2r_i (
        .clk   (rd_clk),
        .rst_n (rst_n),
        .d     (wr_gray),
        .q     (wr_gray_s)
    );

    dcfifo_ram #(.DW(DW), .AW(AW)) ram_i (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );
endmodule

// File: rtl/dcfifo_pflag_chk.sv
module dcfifo_pflag_chk #(
    parameter int AW = 9
) (
    input logic        wr_clk,
    input logic        rd_clk,
    input logic        rst_n,
    input logic        load_n,
    input logic        wr_en_n,
    input logic        retx,
    input logic        full_n,
    input logic        empty_n,
    input logic        enh,
    input logic [AW:0] wr_bin,
    input logic [AW:0] rd_bin
);
    // R5: a write attempt while full leaves the write pointer in place
    p_full_hold_r5: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!full_n && !wr_en_n && load_n) |=> $stable(wr_bin));

    // R6: nothing is consumed while empty
    p_empty_hold_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!empty_n && !retx) |=> $stable(rd_bin));

    // R2: load-mode write edges never move the write pointer
    p_ldwr_ptr_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (!load_n) |=> $stable(wr_bin));

    // R3: load-mode read edges never move the read pointer
    p_ldrd_ptr_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!load_n && !retx) |=> $stable(rd_bin));

    // R8: retransmit rewinds to location zero
    p_rt_zero_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
        retx |=> (rd_bin == '0));

    // R9: mode is held once reset has ended
    p_mode_held_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $stable(enh));
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.AW(AW)) chk_i (
    .wr_clk  (wr_clk),
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .wr_en_n (wr_en_n),
    .retx    (retx),
    .full_n  (full_n),
    .empty_n (empty_n),
    .enh     (enh_q),
    .wr_bin  (wr_bin),
    .rd_bin  (rd_bin)
);

// File: tb/dcfifo_pflag_tb_top.sv
module dcfifo_pflag_tb_top;
    localparam int DW    = 18;
    localparam int DEPTH = 512;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          rst_n, mode_enh, load_n, wr_en_n, wr_en2_n;
    logic          rd_en_n, rd_en2_n, oe_n, retx;
    logic [DW-1:0] din, dout;
    logic          full_n, paf_n, empty_n;

    int   vec_n  = 0;
    int   miss_n = 0;
    bit   done   = 0;
    logic [DW-1:0] mq [$];
    logic [DW-1:0] saved [$];
    logic [DW-1:0] q;

    always #5 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #5 rd_clk = ~rd_clk;
    end

    dcfifo_pflag #(.DW(DW), .DEPTH(DEPTH)) dut_i (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .mode_enh(mode_enh),
        .load_n(load_n), .wr_en_n(wr_en_n), .wr_en2_n(wr_en2_n),
        .rd_en_n(rd_en_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n), .retx(retx),
        .din(din), .dout(dout), .full_n(full_n), .paf_n(paf_n), .empty_n(empty_n)
    );

    function automatic int af_thr(input int off);
        return DEPTH - off;
    endfunction

    function automatic int def_off();
        return DEPTH / 8 - 1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vec_n++;
        if (!ok) begin
            miss_n++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input bit enh);
        load_n = 1; wr_en_n = 1; wr_en2_n = 1; rd_en_n = 1; rd_en2_n = 1;
        oe_n = 1; retx = 0; din = '0; mode_enh = enh; rst_n = 0;
        repeat (4) @(posedge wr_clk);
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk) rst_n = 1;
        mode_enh = ~enh;
        repeat (4) @(posedge rd_clk);
        repeat (2) @(posedge wr_clk);
        mq.delete();
    endtask

    task automatic wr_word(input logic [DW-1:0] d, input bit ld, input bit w2n);
        @(negedge wr_clk);
        din = d; load_n = ~ld; wr_en_n = 0; wr_en2_n = w2n;
        @(negedge wr_clk);
        wr_en_n = 1; load_n = 1; wr_en2_n = 1;
    endtask

    task automatic rd_word(input bit ld, input bit r2n, input bit oen, output logic [DW-1:0] r);
        @(negedge rd_clk);
        load_n = ~ld; rd_en_n = 0; rd_en2_n = r2n; oe_n = oen;
        @(negedge rd_clk);
        rd_en_n = 1; load_n = 1; rd_en2_n = 1; oe_n = 1;
        r = dout;
    endtask

    task automatic settle();
        repeat (6) @(posedge wr_clk);
        repeat (6) @(posedge rd_clk);
        @(negedge rd_clk);
    endtask

    task automatic push(input logic [DW-1:0] d, input bit w2n);
        wr_word(d, 0, w2n);
        if (mq.size() < DEPTH) mq.push_back(d);
    endtask

    task automatic pop_chk(input string req, input bit r2n, input bit oen);
        logic [DW-1:0] e;
        logic [DW-1:0] r;
        rd_word(0, r2n, oen, r);
        e = mq.pop_front();
        chk(r === e, req, int'(r), int'(e));
    endtask

    task automatic flags_chk(input string req);
        chk(empty_n === (mq.size() != 0), {req, " empty_n"}, int'(empty_n), int'(mq.size() != 0));
        chk(full_n === (mq.size() != DEPTH), {req, " full_n"}, int'(full_n), int'(mq.size() != DEPTH));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            miss_n++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0017));

        // R1 reset state, compatible mode
        do_reset(0);
        chk(empty_n === 1'b0, "R1 empty_n", int'(empty_n), 0);
        chk(full_n === 1'b1, "R1 full_n", int'(full_n), 1);
        chk(paf_n === 1'b1, "R1 paf_n", int'(paf_n), 1);
        chk(dout === '0, "R1 dout", int'(dout), 0);

        // R1 defaults, R3 readback order with compatible wrap (R9)
        for (int i = 0; i < 3; i++) begin
            rd_word(1, 1, 1, q);
            chk(q === DW'(def_off()), "R1 R3 default offset", int'(q), def_off());
        end
        // R2 load writes: AE=5, AF=7, wrap to AE=9; read index sits at AF
        wr_word(18'd5, 1, 1);
        wr_word(18'd7, 1, 1);
        wr_word(18'd9, 1, 1);
        rd_word(1, 1, 1, q); chk(q === 18'd7, "R3 separate index AF", int'(q), 7);
        rd_word(1, 1, 1, q); chk(q === 18'd9, "R2 R9 wrap to AE", int'(q), 9);
        rd_word(1, 1, 1, q); chk(q === 18'd7, "R3 AF again", int'(q), 7);
        settle();
        chk(empty_n === 1'b0, "R2 memory untouched", int'(empty_n), 0);

        // R4 R9 random bursts, secondary enables held inactive in compatible mode
        do_reset(0);
        for (int b = 0; b < 12; b++) begin
            int nw, nr;
            nw = $urandom_range(0, 40);
            if (nw > DEPTH - mq.size()) nw = DEPTH - mq.size();
            for (int i = 0; i < nw; i++) push(DW'($urandom), 1);
            settle();
            flags_chk("R5 R6 burst");
            nr = $urandom_range(0, mq.size());
            if (nr > 40) nr = 40;
            for (int i = 0; i < nr; i++) pop_chk("R4 R9 order", 1, 1);
            settle();
            flags_chk("R5 R6 burst");
        end
        while (mq.size() != 0) pop_chk("R4 drain", 1, 1);
        settle();

        // R7 direct almost-full flag at default offset, R5 full and overrun
        do_reset(0);
        for (int i = 0; i < af_thr(def_off()) - 1; i++) push(DW'(i * 3 + 1), 1);
        settle();
        chk(paf_n === 1'b1, "R7 below threshold", int'(paf_n), 1);
        push(18'h2aaaa, 1);
        chk(paf_n === 1'b0, "R7 direct flag at threshold", int'(paf_n), 0);
        while (mq.size() < DEPTH) push(DW'($urandom), 1);
        settle();
        flags_chk("R5 full");
        wr_word(18'h3ffff, 0, 1);
        settle();
        chk(full_n === 1'b0, "R5 still full", int'(full_n), 0);
        while (mq.size() != 0) pop_chk("R5 overrun dropped", 1, 1);
        settle();
        flags_chk("R6 empty");
        q = dout;
        begin
            logic [DW-1:0] r;
            rd_word(0, 1, 1, r);
            chk(r === q, "R6 read while empty", int'(r), int'(q));
        end

        // R8 retransmit
        do_reset(0);
        for (int i = 0; i < 6; i++) push(DW'($urandom), 1);
        saved = mq;
        settle();
        for (int i = 0; i < 3; i++) pop_chk("R8 first pass", 1, 1);
        @(negedge rd_clk) retx = 1;
        @(negedge rd_clk) retx = 0;
        settle();
        mq = saved;
        for (int i = 0; i < 6; i++) pop_chk("R8 replay", 1, 1);
        settle();
        flags_chk("R8 after replay");

        // Enhanced mode
        do_reset(1);
        wr_word(18'd10, 1, 0);
        wr_word(18'd20, 1, 0);
        wr_word(18'h3ffff, 1, 0);   // control: only bits 5 and 4 kept
        rd_word(1, 0, 0, q); chk(q === 18'd10, "R3 enh AE", int'(q), 10);
        rd_word(1, 0, 0, q); chk(q === 18'd20, "R3 enh AF", int'(q), 20);
        rd_word(1, 0, 0, q); chk(q === 18'h30, "R3 ctrl readback", int'(q), 'h30);
        rd_word(1, 0, 0, q); chk(q === 18'd10, "R3 enh wrap", int'(q), 10);

        // R10 second write enable
        wr_word(18'h1234, 0, 1);
        settle();
        chk(empty_n === 1'b0, "R10 write blocked by wr_en2_n", int'(empty_n), 0);
        push(18'h1234, 0);
        settle();
        chk(empty_n === 1'b1, "R10 write with both enables", int'(empty_n), 1);

        // R11 read gating
        rd_word(0, 1, 0, q);
        chk(q === 18'd10, "R11 read blocked by rd_en2_n", int'(q), 10);
        rd_word(0, 0, 1, q);
        chk(q === 18'd10, "R11 read blocked by oe_n", int'(q), 10);
        rd_word(1, 0, 0, q);
        chk(q === 18'd20, "R3 load read between FIFO reads", int'(q), 20);
        pop_chk("R11 R3 read with all enables", 0, 0);
        settle();
        flags_chk("R11 empty after read");

        // R12 registered almost-full flag, offset 20
        for (int i = 0; i < af_thr(20) - 1; i++) push(DW'(i), 0);
        settle();
        chk(paf_n === 1'b1, "R12 below threshold", int'(paf_n), 1);
        push(18'h155, 0);
        chk(paf_n === 1'b1, "R12 one edge later only", int'(paf_n), 1);
        @(negedge wr_clk);
        chk(paf_n === 1'b0, "R12 registered flag", int'(paf_n), 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    end
endmodule